// File: doc/BRIEF.md
# Peripheral Power-Down Control Bank

This block holds one shutdown bit per peripheral module, arranged in a small bank of byte-wide registers on a simple synchronous register bus. Setting a bit cuts that peripheral off completely. Its gated-clock enable drops and its register-access enable drops, so the surrounding decode discards any access to that peripheral's registers. Clearing the bit brings the peripheral back.

This is a different mechanism from the ordinary run/stop enable that each peripheral keeps in its own control register. That enable only halts operation and leaves the registers writable. The bank never touches that enable.

One bit, the shutdown bit of the real-time clock, is guarded. It changes only on the single bus access that directly follows a two-byte key sequence written to a dedicated key address. Every other write to its register updates the other bits and leaves the guarded bit as it was.

Top module: `pdc_bank`

## Requirements
- R1: After reset every shutdown bit is 0. Every `periph_acc_en` and `periph_clk_en` bit is 1, and reading any shutdown register returns 0x00.
- R2: Shutdown register i sits at address i (i = 0..3), and its bit b controls peripheral 8*i+b. Writing 1 sets the bit and writing 0 clears it. A read (`bus_rd`=1) returns the stored value on `bus_rdata` in the same cycle. With `bus_rd`=0, `bus_rdata` is 0.
- R3: `periph_acc_en[p]` is the inverse of shutdown bit p. It changes right after the clock edge that captures the write.
- R4: `periph_clk_en[p]` follows the same inverse one clock edge later than `periph_acc_en[p]`, through a register.
- R5: Unimplemented positions are bit 0 of register 0, and bits 5 and 7 of register 3. They read as 0, ignore writes, and keep both enables of their peripheral at 1.
- R6: The guarded bit is bit 6 of register 1 (peripheral 14). A plain write to register 1 leaves it unchanged, but the same write still updates the other bits of register 1.
- R7: A write of 0x55 to key address 0x8, followed directly by a write of 0xAA to 0x8, arms the unlock. The next bus access, if it is a write to register 1, may change the guarded bit. Idle cycles (no access) between the key writes or after them do not disturb the sequence.
- R8: A wrong second key byte, or any other bus access (read or write) between the two key writes, returns the unlock to idle. A following write to register 1 then cannot change the guarded bit.
- R9: The armed state is consumed by the first bus access that follows it. This holds whether that access is a read, a write elsewhere, or a write to register 1 that leaves the bit unchanged. Later writes find the bit locked again.
- R10: The key address and all unmapped addresses read as 0x00. Writes to them change no shutdown bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset (power-on / brown-out) |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| periph_clk_en | output | 32 | Registered clock-gate enable per peripheral |
| periph_acc_en | output | 32 | Register-access enable per peripheral |

## Verification
The bench goes after the unlock's fragility. It sends a wrong second key byte, a foreign write or a read wedged between the key bytes, and a read that consumes the armed state. A design that tracked only key writes, or kept the unlock open for several accesses, would let the guarded bit move in these cases. It also checks that idle cycles between or after the key writes leave the sequence intact, so a design that timed out on idle cycles would wrongly refuse the change. Every cycle compares both enable vectors, which catches a clock enable that moves in the same cycle as the register, or one that moves two cycles late. Writes of all ones show whether unimplemented positions latch data.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_KEY1  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/pdc_unlock_fsm.sv
module pdc_unlock_fsm
  import pdc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int KEY_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              armed
);
  unlock_e st_q;
  logic    key_wr;
  logic    any_acc;

  assign key_wr  = bus_wr && (bus_addr == ADDR_W'(KEY_ADDR));
  assign any_acc = bus_wr || bus_rd;

  // Idle cycles hold the state; every access advances or cancels it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= UL_IDLE;
    end else if (any_acc) begin
      case (st_q)
        UL_IDLE: st_q <= (key_wr && bus_wdata == DATA_W'(KEY_FIRST))  ? UL_KEY1  : UL_IDLE;
        UL_KEY1: st_q <= (key_wr && bus_wdata == DATA_W'(KEY_SECOND)) ? UL_ARMED : UL_IDLE;
        default: st_q <= UL_IDLE;
      endcase
    end
  end

  assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/pdc_shutdown_regs.sv
module pdc_shutdown_regs #(
  parameter int                           NUM_REGS  = 4,
  parameter int                           DATA_W    = 8,
  parameter int                           ADDR_W    = 4,
  parameter int                           BASE_ADDR = 0,
  parameter logic [NUM_REGS*DATA_W-1:0]   IMPL_MASK = 32'h5FFF_FFFE,
  parameter int                           PROT_REG  = 1,
  parameter int                           PROT_BIT  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       armed,
  output logic [NUM_REGS*DATA_W-1:0] sd_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] IMPL_I = IMPL_MASK[i*DATA_W +: DATA_W];
    localparam logic [DATA_W-1:0] PROT_I =
      (i == PROT_REG) ? (DATA_W'(1) << PROT_BIT) : '0;

    logic [DATA_W-1:0] sd_q;
    logic [DATA_W-1:0] wmask;
    logic              hit;

    assign hit   = bus_wr && (bus_addr == ADDR_W'(BASE_ADDR + i));
    assign wmask = IMPL_I & ~(armed ? '0 : PROT_I);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sd_q <= '0;
      end else if (hit) begin
        sd_q <= (sd_q & ~wmask) | (bus_wdata & wmask);
      end
    end

    assign sd_flat[i*DATA_W +: DATA_W] = sd_q;
  end
endmodule

// File: rtl/pdc_gate_out.sv
module pdc_gate_out #(
  parameter int NUM_PERIPH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] sd_flat,
  output logic [NUM_PERIPH-1:0] periph_acc_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en
);
  logic [NUM_PERIPH-1:0] clk_en_q;

  assign periph_acc_en = ~sd_flat;

  // Registered so that gated clocks see a clean enable edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_en_q <= '1;
    else        clk_en_q <= ~sd_flat;
  end

  assign periph_clk_en = clk_en_q;
endmodule

// File: rtl/pdc_bank.sv
module pdc_bank #(
  parameter int                         NUM_REGS  = 4,
  parameter int                         DATA_W    = 8,
  parameter int                         ADDR_W    = 4,
  parameter int                         BASE_ADDR = 0,
  parameter int                         KEY_ADDR  = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] IMPL_MASK = 32'h5FFF_FFFE,
  parameter int                         PROT_REG  = 1,
  parameter int                         PROT_BIT  = 6,
  localparam int                        NUM_PERIPH = NUM_REGS * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic [NUM_PERIPH-1:0] periph_acc_en
);
  logic                  armed;
  logic [NUM_PERIPH-1:0] sd_flat;

  pdc_unlock_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .armed(armed)
  );

  pdc_shutdown_regs #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .IMPL_MASK(IMPL_MASK),
    .PROT_REG(PROT_REG), .PROT_BIT(PROT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .armed(armed), .sd_flat(sd_flat)
  );

  pdc_gate_out #(
    .NUM_PERIPH(NUM_PERIPH)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .sd_flat(sd_flat),
    .periph_acc_en(periph_acc_en), .periph_clk_en(periph_clk_en)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (bus_addr == ADDR_W'(BASE_ADDR + i)) bus_rdata = sd_flat[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/pdc_bank_chk.sv
module pdc_bank_chk
  import pdc_pkg::*;
#(
  parameter int                         NUM_REGS  = 4,
  parameter int                         DATA_W    = 8,
  parameter int                         ADDR_W    = 4,
  parameter int                         BASE_ADDR = 0,
  parameter int                         KEY_ADDR  = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] IMPL_MASK = 32'h5FFF_FFFE,
  parameter int                         PROT_REG  = 1,
  parameter int                         PROT_BIT  = 6,
  localparam int                        NUM_PERIPH = NUM_REGS * DATA_W,
  localparam int                        PIDX = PROT_REG * DATA_W + PROT_BIT
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [NUM_PERIPH-1:0] periph_clk_en,
  input logic [NUM_PERIPH-1:0] periph_acc_en,
  input logic                  armed,
  input logic [NUM_PERIPH-1:0] sd_flat
);
  p_clk_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    periph_clk_en == $past(periph_acc_en));

  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_flat & ~IMPL_MASK) == '0);

  p_guard_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(BASE_ADDR + PROT_REG) && armed)
    |=> $stable(periph_acc_en[PIDX]));

  p_arm_needs_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(bus_wr && bus_addr == ADDR_W'(KEY_ADDR)
                           && bus_wdata == DATA_W'(KEY_SECOND)));

  p_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (bus_wr || bus_rd)) |=> !armed);
endmodule

bind pdc_bank pdc_bank_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .KEY_ADDR(KEY_ADDR), .IMPL_MASK(IMPL_MASK),
  .PROT_REG(PROT_REG), .PROT_BIT(PROT_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .periph_clk_en(periph_clk_en), .periph_acc_en(periph_acc_en),
  .armed(armed), .sd_flat(sd_flat)
);

// File: tb/pdc_bank_tb.sv
`timescale 1ns/1ps
module pdc_bank_tb;
  localparam logic [31:0] MASK = 32'h5FFF_FFFE;  // R5 positions

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] periph_clk_en;
  logic [31:0] periph_acc_en;

  int checks = 0;
  int errors = 0;

  logic [72:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_sd   = '0;
  logic [31:0] m_prev = '0;
  int          m_st   = 0;  // 0 idle, 1 first key seen, 2 armed

  always #2.5 clk = ~clk;

  pdc_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_clk_en(periph_clk_en), .periph_acc_en(periph_acc_en)
  );

  // Driver: one bus cycle per call, expectation pushed before the model steps.
  task automatic op(input bit wr, input bit rd, input logic [3:0] addr,
                    input logic [7:0] data, input string tag);
    logic [7:0] exp_rd;
    logic [7:0] nv;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = data;
    exp_rd = '0;
    if (rd && addr < 4) exp_rd = m_sd[addr*8 +: 8];
    exp_q.push_back({rd, exp_rd, ~m_sd, ~m_prev});
    tag_q.push_back(tag);
    m_prev = m_sd;
    if (wr && addr < 4) begin
      nv = data & MASK[addr*8 +: 8];
      if (addr == 4'd1 && m_st != 2) nv[6] = m_sd[14];
      m_sd[addr*8 +: 8] = nv;
    end
    if (wr || rd) begin
      if (m_st == 0)      m_st = (wr && addr == 4'h8 && data == 8'h55) ? 1 : 0;
      else if (m_st == 1) m_st = (wr && addr == 4'h8 && data == 8'hAA) ? 2 : 0;
      else                m_st = 0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string t);
    op(1'b1, 1'b0, a, d, t);
  endtask
  task automatic rd(input logic [3:0] a, input string t);
    op(1'b0, 1'b1, a, 8'h00, t);
  endtask
  task automatic idle(input string t);
    op(1'b0, 1'b0, 4'h0, 8'h00, t);
  endtask

  // Monitor: pops one expectation per driven cycle, samples mid-low phase.
  initial begin
    logic [72:0] e;
    string       t;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (periph_acc_en !== e[63:32]) begin
          errors++;
          $display("FAIL %s acc_en got %h exp %h", t, periph_acc_en, e[63:32]);
        end
        checks++;
        if (periph_clk_en !== e[31:0]) begin
          errors++;
          $display("FAIL %s clk_en got %h exp %h", t, periph_clk_en, e[31:0]);
        end
        if (e[72]) begin
          checks++;
          if (bus_rdata !== e[71:64]) begin
            errors++;
            $display("FAIL %s rdata got %h exp %h", t, bus_rdata, e[71:64]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle("R1");
    for (int i = 0; i < 4; i++) rd(4'(i), "R1");
    // R2 R3 R4 R5 set and clear with unimplemented positions
    wr(4'd0, 8'hFF, "R2"); rd(4'd0, "R5"); idle("R4"); idle("R3");
    wr(4'd3, 8'hFF, "R5"); rd(4'd3, "R5");
    wr(4'd0, 8'h00, "R2"); rd(4'd0, "R2"); idle("R4");
    wr(4'd2, 8'hA5, "R3"); idle("R4"); rd(4'd2, "R2");
    // R6 plain write leaves guarded bit
    wr(4'd1, 8'hFF, "R6"); rd(4'd1, "R6");
    // R7 unlock and change guarded bit
    wr(4'h8, 8'h55, "R7"); wr(4'h8, 8'hAA, "R7"); wr(4'd1, 8'hFF, "R7");
    rd(4'd1, "R7"); idle("R4");
    // R9 one-shot: clears it, then relocked
    wr(4'h8, 8'h55, "R9"); wr(4'h8, 8'hAA, "R9"); wr(4'd1, 8'h00, "R9");
    wr(4'd1, 8'h40, "R9"); rd(4'd1, "R9");
    // R8 wrong second byte
    wr(4'h8, 8'h55, "R8"); wr(4'h8, 8'h12, "R8"); wr(4'h8, 8'hAA, "R8");
    wr(4'd1, 8'h40, "R8"); rd(4'd1, "R8");
    // R8 foreign write between keys
    wr(4'h8, 8'h55, "R8"); wr(4'd2, 8'h01, "R8"); wr(4'h8, 8'hAA, "R8");
    wr(4'd1, 8'h40, "R8"); rd(4'd1, "R8");
    // R8 read between keys
    wr(4'h8, 8'h55, "R8"); rd(4'd3, "R8"); wr(4'h8, 8'hAA, "R8");
    wr(4'd1, 8'h40, "R8"); rd(4'd1, "R8");
    // R9 read consumes armed state
    wr(4'h8, 8'h55, "R9"); wr(4'h8, 8'hAA, "R9"); rd(4'd0, "R9");
    wr(4'd1, 8'h40, "R9"); rd(4'd1, "R9");
    // R7 idle cycles do not disturb the sequence
    wr(4'h8, 8'h55, "R7"); idle("R7"); idle("R7"); wr(4'h8, 8'hAA, "R7");
    idle("R7"); wr(4'd1, 8'h40, "R7"); rd(4'd1, "R7");
    // R9 write elsewhere consumes it
    wr(4'h8, 8'h55, "R9"); wr(4'h8, 8'hAA, "R9"); wr(4'd2, 8'h33, "R9");
    wr(4'd1, 8'h00, "R9"); rd(4'd1, "R9"); rd(4'd2, "R9");
    // R10 key and unmapped addresses
    wr(4'h8, 8'hFF, "R10"); rd(4'h8, "R10");
    wr(4'h5, 8'hFF, "R10"); rd(4'h5, "R10"); rd(4'hF, "R10");
    for (int i = 0; i < 4; i++) rd(4'(i), "R10");
    idle("R4"); idle("R4");
    @(negedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule